// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Coarse Fill Levels

This block moves data words from a producer clock domain to a consumer clock domain. The two clocks have no fixed relation. The producer offers a word with `put` and stops while `full` is high. The consumer sees the oldest stored word on `dout` as soon as `valid` rises. Asserting `got` in a cycle where `valid` is high takes that word away, and the next one is then presented.

Each side also reports a coarse, conservative measure of its own view of the queue. The read side gives `fillLevel`, a lower bound on the stored words. The write side gives `freeLevel`, a lower bound on the words it can still push. Each measure is quantized to a parameterized number of bits. A width of zero turns that measure off, and its port becomes one constant-zero bit.

Pointers cross between the domains in Gray code through two-flop synchronizers. Each domain has its own synchronous reset. An optional register stage on the read data keeps the fall-through behaviour and holds one extra word.

Top module: `xclk_fwft_fifo`

## Requirements
- R1: After both resets have been released, `valid` and `full` are 0, `fillLevel` is 0, and `freeLevel` shows all ones.
- R2: Whenever `valid` is 1, `dout` holds the oldest word not yet taken. A `got` while `valid` is 1 removes that word, and the following word (if any) is presented next.
- R3: With unrelated write and read clocks, every accepted word leaves the FIFO exactly once, unchanged and in acceptance order.
- R4: The memory holds DEPTH = MIN_DEPTH rounded up to a power of two words. With the output register enabled, total capacity is DEPTH+1. `full` is 1 once the capacity is reached, and a `put` while `full` is 1 stores nothing.
- R5: A `got` while `valid` is 0 has no effect: no stored word is lost or skipped.
- R6: `fillLevel` never exceeds min(floor(occupancy * 2^FILL_RD_BITS / DEPTH), 2^FILL_RD_BITS - 1). A value k means at least k/2^FILL_RD_BITS of DEPTH is stored. When the write side is idle, it equals that bound.
- R7: `freeLevel` never exceeds the same quantization applied to the guaranteed space min(DEPTH, capacity - occupancy). When the read side is idle, it equals that value.
- R8: After both sides have been idle for at least 10 cycles of each clock, `valid` is 1 exactly when occupancy > 0, and `full` is 1 exactly when occupancy equals capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRst | input | 1 | Synchronous reset, write side, active high |
| put | input | 1 | Push `din` when not full |
| din | input | DATA_W | Word to store |
| full | output | 1 | No room for another word |
| freeLevel | output | max(FREE_WR_BITS,1) | Quantized guaranteed free space |
| rdClk | input | 1 | Read-side clock |
| rdRst | input | 1 | Synchronous reset, read side, active high |
| got | input | 1 | Consumer has taken the word on `dout` |
| valid | output | 1 | `dout` holds the oldest stored word |
| dout | output | DATA_W | Head word |
| fillLevel | output | max(FILL_RD_BITS,1) | Quantized guaranteed stored words |

## Verification
The case that matters is a push and a pop arriving in the same period. The write pointer then advances while the other domain is sampling the read pointer, and the reverse. The worst moment is a pop that frees the last slot while the producer is still pressing `put` against `full`. The bench provokes this by running producer and consumer together at different duty cycles, once with a fast reader and once with a half-rate reader that keeps the queue at capacity. On every edge of each clock it compares the head word against a behavioural queue and holds each level indicator under the bound computed from that queue.

// File: rtl/xclk_fwft_pkg.sv
package xclk_fwft_pkg;

  // Flops in each pointer synchronizer
  localparam int unsigned SYNC_STAGES = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write din into the cell at wrAddr (write clock)
    logic headLoad;  // fetch the cell at rdAddr into the head register (read clock)
  } storeCmd_t;

endpackage

// File: rtl/xclk_fwft_level.sv
// Quantizes a word count into a few bits of fill fraction, rounding down.
module xclk_fwft_level #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned LVL_BITS = 2,
  parameter int unsigned CNT_W    = 6
) (
  input  logic [CNT_W-1:0]                        count,
  output logic [((LVL_BITS > 0) ? LVL_BITS : 1)-1:0] level
);

  generate
    if (LVL_BITS == 0) begin : g_off
      logic unusedCount;
      assign unusedCount = ^count;
      assign level       = '0;
    end else begin : g_on
      localparam int unsigned SHIFT = ADDR_W - LVL_BITS;
      localparam logic [CNT_W-1:0] TOP = CNT_W'((1 << LVL_BITS) - 1);
      logic [CNT_W-1:0] scaled;
      assign scaled = count >> SHIFT;
      assign level  = (scaled > TOP) ? TOP[LVL_BITS-1:0] : scaled[LVL_BITS-1:0];
    end
  endgenerate

endmodule

// File: rtl/xclk_fwft_ctrl.sv
// Pointer control for both clock domains: Gray crossing, flow control, fill levels.
module xclk_fwft_ctrl
  import xclk_fwft_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned OUT_REG   = 1,
  parameter int unsigned FILL_BITS = 2,
  parameter int unsigned FREE_BITS = 2
) (
  input  logic                                          wrClk,
  input  logic                                          wrRst,
  input  logic                                          put,
  output logic                                          full,
  output logic [((FREE_BITS > 0) ? FREE_BITS : 1)-1:0]  freeLevel,
  input  logic                                          rdClk,
  input  logic                                          rdRst,
  input  logic                                          got,
  output logic                                          valid,
  output logic [((FILL_BITS > 0) ? FILL_BITS : 1)-1:0]  fillLevel,
  output storeCmd_t                                     cmd,
  output logic [ADDR_W-1:0]                             wrAddr,
  output logic [ADDR_W-1:0]                             rdAddr
);

  localparam int unsigned PTR_W = ADDR_W + 1;
  localparam int unsigned CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = int'(PTR_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrPtrBin, wrPtrGray, rdSyncBin, wrUsed;
  logic [PTR_W-1:0] rdGrayPipe [SYNC_STAGES];
  logic [CNT_W-1:0] freeCount;
  logic             wrAccept;

  // ---------------- read domain -----------------
  logic [PTR_W-1:0] rdPtrBin, rdPtrGray, wrSyncBin, memCount;
  logic [PTR_W-1:0] wrGrayPipe [SYNC_STAGES];
  logic [CNT_W-1:0] occupancy;
  logic             memAvail, advance;

  assign rdSyncBin = fromGray(rdGrayPipe[SYNC_STAGES-1]);
  assign wrUsed    = wrPtrBin - rdSyncBin;
  assign full      = (wrUsed == DEPTH_P);
  assign wrAccept  = put && !full;
  assign freeCount = {1'b0, DEPTH_P - wrUsed};

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
    end else if (wrAccept) begin
      wrPtrBin  <= wrPtrBin + 1'b1;
      wrPtrGray <= toGray(wrPtrBin + 1'b1);
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrRst) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) rdGrayPipe[i] <= '0;
    end else begin
      rdGrayPipe[0] <= rdPtrGray;
      for (int i = 1; i < int'(SYNC_STAGES); i++) rdGrayPipe[i] <= rdGrayPipe[i-1];
    end
  end

  xclk_fwft_level #(
    .ADDR_W   (ADDR_W),
    .LVL_BITS (FREE_BITS),
    .CNT_W    (CNT_W)
  ) uFree (
    .count (freeCount),
    .level (freeLevel)
  );

  // read side
  assign wrSyncBin = fromGray(wrGrayPipe[SYNC_STAGES-1]);
  assign memCount  = wrSyncBin - rdPtrBin;
  assign memAvail  = (memCount != '0);

  generate
    if (OUT_REG != 0) begin : g_headReg
      logic headValid;
      assign advance = memAvail && (!headValid || got);
      always_ff @(posedge rdClk) begin
        if (rdRst)        headValid <= 1'b0;
        else if (advance) headValid <= 1'b1;
        else if (got)     headValid <= 1'b0;
      end
      assign valid     = headValid;
      assign occupancy = {1'b0, memCount} + CNT_W'(headValid);
    end else begin : g_direct
      assign advance   = got && memAvail;
      assign valid     = memAvail;
      assign occupancy = {1'b0, memCount};
    end
  endgenerate

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
    end else if (advance) begin
      rdPtrBin  <= rdPtrBin + 1'b1;
      rdPtrGray <= toGray(rdPtrBin + 1'b1);
    end
  end

  always_ff @(posedge rdClk) begin
    if (rdRst) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) wrGrayPipe[i] <= '0;
    end else begin
      wrGrayPipe[0] <= wrPtrGray;
      for (int i = 1; i < int'(SYNC_STAGES); i++) wrGrayPipe[i] <= wrGrayPipe[i-1];
    end
  end

  xclk_fwft_level #(
    .ADDR_W   (ADDR_W),
    .LVL_BITS (FILL_BITS),
    .CNT_W    (CNT_W)
  ) uFill (
    .count (occupancy),
    .level (fillLevel)
  );

  assign cmd    = '{wrEn: wrAccept, headLoad: advance};
  assign wrAddr = wrPtrBin[ADDR_W-1:0];
  assign rdAddr = rdPtrBin[ADDR_W-1:0];

  // ---------------- assertions ----------------
  assert_put_full_ignored_R4: assert property (@(posedge wrClk) disable iff (wrRst)
    (put && full) |=> $stable(wrPtrBin));

  assert_no_overflow_R4: assert property (@(posedge wrClk) disable iff (wrRst)
    (wrPtrBin - rdSyncBin) <= DEPTH_P);

  assert_wr_gray_step_R3: assert property (@(posedge wrClk) disable iff (wrRst)
    $countones(wrPtrGray ^ $past(wrPtrGray)) <= 1);

  assert_rd_gray_step_R3: assert property (@(posedge rdClk) disable iff (rdRst)
    $countones(rdPtrGray ^ $past(rdPtrGray)) <= 1);

  assert_no_underflow_R5: assert property (@(posedge rdClk) disable iff (rdRst)
    (wrSyncBin - rdPtrBin) <= DEPTH_P);

  assert_got_idle_R5: assert property (@(posedge rdClk) disable iff (rdRst)
    (got && !valid && !memAvail) |=> $stable(rdPtrBin));

endmodule

// File: rtl/xclk_fwft_store.sv
// Data storage: inferred memory written on the write clock, head word on the read side.
module xclk_fwft_store
  import xclk_fwft_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned OUT_REG = 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  storeCmd_t         cmd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wrClk) begin
    if (cmd.wrEn) cells[wrAddr] <= din;
  end

  generate
    if (OUT_REG != 0) begin : g_outReg
      logic [DATA_W-1:0] headQ;
      always_ff @(posedge rdClk) begin
        if (cmd.headLoad) headQ <= cells[rdAddr];
      end
      assign dout = headQ;
    end else begin : g_comb
      assign dout = cells[rdAddr];
    end
  endgenerate

endmodule

// File: rtl/xclk_fwft_fifo.sv
// Dual-clock FIFO, fall-through read side, quantized fill levels on both sides.
module xclk_fwft_fifo
  import xclk_fwft_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MIN_DEPTH    = 12,
  parameter int unsigned OUT_REG      = 1,
  parameter int unsigned FREE_WR_BITS = 2,
  parameter int unsigned FILL_RD_BITS = 2
) (
  input  logic                                             wrClk,
  input  logic                                             wrRst,
  input  logic                                             put,
  input  logic [DATA_W-1:0]                                din,
  output logic                                             full,
  output logic [((FREE_WR_BITS > 0) ? FREE_WR_BITS : 1)-1:0] freeLevel,
  input  logic                                             rdClk,
  input  logic                                             rdRst,
  input  logic                                             got,
  output logic                                             valid,
  output logic [DATA_W-1:0]                                dout,
  output logic [((FILL_RD_BITS > 0) ? FILL_RD_BITS : 1)-1:0] fillLevel
);

  localparam int unsigned ADDR_W = $clog2(MIN_DEPTH);

  storeCmd_t         cmd;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  xclk_fwft_ctrl #(
    .ADDR_W    (ADDR_W),
    .OUT_REG   (OUT_REG),
    .FILL_BITS (FILL_RD_BITS),
    .FREE_BITS (FREE_WR_BITS)
  ) uCtrl (
    .wrClk     (wrClk),
    .wrRst     (wrRst),
    .put       (put),
    .full      (full),
    .freeLevel (freeLevel),
    .rdClk     (rdClk),
    .rdRst     (rdRst),
    .got       (got),
    .valid     (valid),
    .fillLevel (fillLevel),
    .cmd       (cmd),
    .wrAddr    (wrAddr),
    .rdAddr    (rdAddr)
  );

  xclk_fwft_store #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .OUT_REG (OUT_REG)
  ) uStore (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .cmd    (cmd),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .din    (din),
    .dout   (dout)
  );

  assert_head_known_R2: assert property (@(posedge rdClk) disable iff (rdRst)
    valid |-> !$isunknown(dout));

endmodule

// File: tb/xclk_fwft_fifo_test.sv
`timescale 1ns/1ps
module xclk_fwft_fifo_test;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;   // MIN_DEPTH 12 rounded up
  localparam int CAP    = 17;   // DEPTH plus the head register
  localparam int SHIFT  = 2;    // ADDR_W - level bits
  localparam int LMAX   = 3;

  logic wrClk = 1'b0, rdClk = 1'b0;
  always #2.5 wrClk = ~wrClk;   // 200 MHz
  always #3.7 rdClk = ~rdClk;   // unrelated read clock

  logic              wrRst, rdRst, put, got, full, valid;
  logic [DATA_W-1:0] din, dout;
  logic [1:0]        freeLevel, fillLevel;

  xclk_fwft_fifo #(
    .DATA_W(DATA_W), .MIN_DEPTH(12), .OUT_REG(1), .FREE_WR_BITS(2), .FILL_RD_BITS(2)
  ) uut (
    .wrClk(wrClk), .wrRst(wrRst), .put(put), .din(din), .full(full), .freeLevel(freeLevel),
    .rdClk(rdClk), .rdRst(rdRst), .got(got), .valid(valid), .dout(dout), .fillLevel(fillLevel)
  );

  int checks = 0, fails = 0, accepted = 0, popped = 0;
  bit live = 1'b0;
  logic [DATA_W-1:0] model[$];
  logic [DATA_W-1:0] wrData = 8'h30;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lvl(input int n);
    int s = n >> SHIFT;
    return (s > LMAX) ? LMAX : s;
  endfunction

  function automatic int trueFree();
    int f = CAP - model.size();
    return (f > DEPTH) ? DEPTH : f;
  endfunction

  // Read-side comparison on every read clock
  always @(negedge rdClk) if (live) begin
    if (valid) begin
      check(model.size() > 0, "R2 valid with nothing stored", model.size(), 1);
      if (model.size() > 0) check(dout == model[0], "R2 head word", dout, model[0]);
    end
    check(int'(fillLevel) <= lvl(model.size()), "R6 fill bound", fillLevel, lvl(model.size()));
  end

  // Write-side comparison on every write clock
  always @(negedge wrClk) if (live) begin
    check(int'(freeLevel) <= lvl(trueFree()), "R7 free bound", freeLevel, lvl(trueFree()));
  end

  task automatic doWrites(input int cycles, input int gapEvery);
    for (int c = 0; c < cycles; c++) begin
      bit acc;
      @(negedge wrClk);
      put = (gapEvery == 0) || (c % gapEvery != 0);
      din = wrData;
      acc = put && !full;
      @(posedge wrClk);
      if (acc) begin
        model.push_back(wrData);
        wrData = wrData + 8'd1;
        accepted++;
      end
    end
    @(negedge wrClk);
    put = 1'b0;
  endtask

  task automatic doReads(input int cycles, input int gapEvery);
    for (int c = 0; c < cycles; c++) begin
      bit take;
      @(negedge rdClk);
      got  = (gapEvery == 0) || (c % gapEvery != 0);
      take = got && valid;
      @(posedge rdClk);
      if (take) begin
        void'(model.pop_front());
        popped++;
      end
    end
    @(negedge rdClk);
    got = 1'b0;
  endtask

  task automatic settleCheck();
    repeat (10) @(negedge wrClk);
    repeat (10) @(negedge rdClk);
    check(valid == (model.size() > 0), "R8 valid settled", valid, model.size() > 0);
    check(int'(fillLevel) == lvl(model.size()), "R6 fill exact", fillLevel, lvl(model.size()));
    @(negedge wrClk);
    check(full == (model.size() == CAP), "R8 full settled", full, model.size() == CAP);
    check(int'(freeLevel) == lvl(trueFree()), "R7 free exact", freeLevel, lvl(trueFree()));
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    put = 0; got = 0; din = '0;
    wrRst = 1; rdRst = 1;
    repeat (4) @(posedge wrClk);
    repeat (4) @(posedge rdClk);
    // resets released in overlapping, staggered fashion
    @(negedge wrClk) wrRst = 0;
    repeat (3) @(negedge rdClk);
    rdRst = 0;
    repeat (4) @(negedge rdClk);
    live = 1'b1;

    // R1 reset state
    @(negedge rdClk);
    check(valid == 0, "R1 valid after reset", valid, 0);
    check(fillLevel == 0, "R1 fillLevel after reset", fillLevel, 0);
    @(negedge wrClk);
    check(full == 0, "R1 full after reset", full, 0);
    check(freeLevel == 2'd3, "R1 freeLevel after reset", freeLevel, 3);

    // R5 got while empty, then one word must still arrive intact
    doReads(12, 0);
    check(popped == 0, "R5 got while empty popped", popped, 0);
    doWrites(1, 0);
    settleCheck();
    check(model.size() == 1, "R5 word kept after idle got", model.size(), 1);

    // R6/R7 quarter steps while the read side is idle
    doWrites(3, 0); settleCheck();   // 4 words
    doWrites(4, 0); settleCheck();   // 8
    doWrites(4, 0); settleCheck();   // 12
    doWrites(4, 0); settleCheck();   // 16

    // R4 capacity and put while full
    doWrites(6, 0);
    check(model.size() == CAP, "R4 capacity", model.size(), CAP);
    settleCheck();
    doWrites(4, 0);
    check(model.size() == CAP, "R4 put while full ignored", model.size(), CAP);

    // R3 drain in order
    doReads(40, 0);
    check(model.size() == 0, "R3 drained", model.size(), 0);
    check(popped == accepted, "R3 each word once", popped, accepted);
    settleCheck();

    // R2/R3 concurrent traffic, fast reader
    fork
      doWrites(600, 3);
      doReads(900, 4);
    join
    doReads(40, 0);
    check(popped == accepted, "R3 concurrent fast reader", popped, accepted);

    // R4/R2 concurrent traffic, slow reader keeps the queue at capacity
    fork
      doWrites(400, 0);
      doReads(500, 2);
    join
    doReads(80, 0);
    check(model.size() == 0, "R3 drained after pressure", model.size(), 0);
    check(popped == accepted, "R3 concurrent slow reader", popped, accepted);
    settleCheck();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule